// File: doc/BRIEF.md
# Power-Good Delay Sequencer

This block sits behind the analog comparators of a supply supervisor and turns their already synchronized flags into an active-high power-good signal. Power-good is raised only after the following have all held without a break for a long qualification time: the upper threshold flag of the power-good input, the absence of an undervoltage flag on the 3.3 V and 5 V rails, an asserted (low) on-request and no latched fault. It drops after a short deglitch once the input or either rail goes bad. A latched fault or a released on-request pulls it low at the next clock edge.

The block also qualifies the lower threshold flag of the power-good input. That flag passes through a deglitch stage and then a further delay stage before the undervoltage-arm output rises. Protection logic elsewhere uses undervoltage-arm to ignore rail undervoltage while the input is still low, and it keeps acting on overvoltage regardless. Every time is a cycle count set by a parameter. The defaults assume a 1 MHz tick. A variant parameter selects either the long or the short rising delay.

Top module: `pg_delay_seq`

## Requirements
- R1: `pwr_good` rises at the (RISE+1)-th consecutive clock edge at which `pgi_upper_ok`=1, `rail33_low`=0, `rail5_low`=0, `on_req_n`=0 and `fault_held`=0 all hold, and never at an edge where any of them fails.
- R2: RISE equals `RISE_LONG_CYC` when `SLOW_VARIANT`=1 and `RISE_SHORT_CYC` when `SLOW_VARIANT`=0.
- R3: A single edge at which any rise condition fails restarts the rising qualification from zero.
- R4: Once high, `pwr_good` stays high through a run of up to `FALL_CYC` edges at which the input or a rail is bad. It goes low at the (`FALL_CYC`+1)-th consecutive such edge. No rising delay applies to the fall.
- R5: `pwr_good` is low after any edge at which `fault_held`=1 or `on_req_n`=1.
- R6: `uv_arm` rises at the (`LO_DEG_CYC`+`LO_DLY_CYC`+1)-th consecutive edge with `pgi_lower_ok`=1. A shorter run leaves it low.
- R7: `uv_arm` is low after any edge at which `pgi_lower_ok`=0, and the lower qualification then restarts from zero.
- R8: While `rst_n` is low, `pwr_good` and `uv_arm` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgi_upper_ok | input | 1 | Power-good input above its upper threshold |
| pgi_lower_ok | input | 1 | Power-good input above its lower threshold |
| rail33_low | input | 1 | 3.3 V rail below its undervoltage threshold |
| rail5_low | input | 1 | 5 V rail below its undervoltage threshold |
| on_req_n | input | 1 | Debounced on-request, low means on |
| fault_held | input | 1 | Protection fault is latched |
| pwr_good | output | 1 | Active-high power-good |
| uv_arm | output | 1 | Enables undervoltage protection elsewhere |

## Verification
The bench builds two instances side by side. One has `SLOW_VARIANT`=0 with a short rise of 30 cycles. The other has `SLOW_VARIANT`=1 with a long rise of 60 cycles. Both share a fall deglitch of 4 cycles and a lower-threshold stage of 5 plus 9 cycles. These small counts let the exact rise edge, the edge where a dropout becomes a fall, and the restart after a one-cycle glitch each be reached many times under random stimulus. Both variants are compared in the same run, so a swapped delay selection is caught.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

   // Width of a counter that must hold the value lim.
   function automatic int unsigned run_width(input int unsigned lim);
      return (lim < 1) ? 1 : $clog2(lim + 1);
   endfunction

   // Monitored levels that decide whether power is still good.
   typedef struct packed {
      logic upper_ok;
      logic r33_low;
      logic r5_low;
   } mon_flags_t;

   function automatic logic mon_healthy(input mon_flags_t f);
      return f.upper_ok & ~f.r33_low & ~f.r5_low;
   endfunction

endpackage

// File: rtl/pg_run_counter.sv
// Counts consecutive cycles with run high; saturates at LIMIT.
module pg_run_counter #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic reached
);
   import pg_seq_pkg::*;

   localparam int unsigned W = run_width(LIMIT);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pg_run_counter: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (cnt_q != LIM_V)
         cnt_q <= cnt_q + 1'b1;
   end

   assign reached = (cnt_q == LIM_V);

   // R3
   run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

   // R3
   run_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reached |-> $past(run));

endmodule

// File: rtl/pg_good_ctrl.sv
// Asymmetric power-good: long qualified rise, short deglitched fall.
module pg_good_ctrl #(
   parameter int unsigned RISE_CYC = 150000,
   parameter int unsigned FALL_CYC = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic all_ok,
   input  logic mon_ok,
   input  logic force_off,
   output logic pwr_good
);
   logic rise_done;
   logic fall_done;
   logic pg_q;
   logic fall_run;

   assign fall_run = pg_q & ~mon_ok;

   pg_run_counter #(.LIMIT(RISE_CYC)) i_rise_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (all_ok),
      .reached (rise_done)
   );

   pg_run_counter #(.LIMIT(FALL_CYC)) i_fall_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (fall_run),
      .reached (fall_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         pg_q <= 1'b0;
      else if (force_off)
         pg_q <= 1'b0;
      else if (!pg_q)
         pg_q <= rise_done & all_ok;
      else if (fall_done & ~mon_ok)
         pg_q <= 1'b0;
   end

   assign pwr_good = pg_q;

   // R4
   pg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_q && mon_ok && !force_off) |=> pg_q);

   // R4
   pg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_q && fall_done && !mon_ok) |=> !pg_q);

endmodule

// File: rtl/pg_lower_qual.sv
// Lower-threshold qualifier: deglitch stage, then optional delay stage.
module pg_lower_qual #(
   parameter int unsigned DEG_CYC = 296,
   parameter int unsigned DLY_CYC = 4800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lower_ok,
   output logic arm
);
   logic deg_done;
   logic stage_done;
   logic arm_q;

   pg_run_counter #(.LIMIT(DEG_CYC)) i_deg_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (lower_ok),
      .reached (deg_done)
   );

   generate
      if (DLY_CYC == 0) begin : g_no_delay
         assign stage_done = deg_done;
      end else begin : g_delay
         logic dly_run;
         assign dly_run = lower_ok & deg_done;
         pg_run_counter #(.LIMIT(DLY_CYC)) i_dly_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (dly_run),
            .reached (stage_done)
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         arm_q <= 1'b0;
      else
         arm_q <= lower_ok & stage_done;
   end

   assign arm = arm_q;

   // R6
   arm_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm_q) |-> $past(deg_done));

endmodule

// File: rtl/pg_delay_seq.sv
module pg_delay_seq #(
   parameter bit          SLOW_VARIANT   = 1'b1,
   parameter int unsigned RISE_LONG_CYC  = 300000,
   parameter int unsigned RISE_SHORT_CYC = 150000,
   parameter int unsigned FALL_CYC       = 150,
   parameter int unsigned LO_DEG_CYC     = 296,
   parameter int unsigned LO_DLY_CYC     = 4800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pgi_upper_ok,
   input  logic pgi_lower_ok,
   input  logic rail33_low,
   input  logic rail5_low,
   input  logic on_req_n,
   input  logic fault_held,
   output logic pwr_good,
   output logic uv_arm
);
   import pg_seq_pkg::*;

   localparam int unsigned RISE_CYC = SLOW_VARIANT ? RISE_LONG_CYC : RISE_SHORT_CYC;

   generate
      if (RISE_LONG_CYC < RISE_SHORT_CYC) begin : g_bad_rise
         $error("pg_delay_seq: long rise must not be shorter than short rise");
      end
      if (FALL_CYC < 1 || LO_DEG_CYC < 1) begin : g_bad_deg
         $error("pg_delay_seq: deglitch counts must be at least 1");
      end
   endgenerate

   mon_flags_t flags;
   logic       mon_ok;
   logic       force_off;
   logic       all_ok;

   assign flags     = '{upper_ok: pgi_upper_ok, r33_low: rail33_low, r5_low: rail5_low};
   assign mon_ok    = mon_healthy(flags);
   assign force_off = fault_held | on_req_n;
   assign all_ok    = mon_ok & ~force_off;

   pg_good_ctrl #(
      .RISE_CYC (RISE_CYC),
      .FALL_CYC (FALL_CYC)
   ) i_good (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_ok    (all_ok),
      .mon_ok    (mon_ok),
      .force_off (force_off),
      .pwr_good  (pwr_good)
   );

   pg_lower_qual #(
      .DEG_CYC (LO_DEG_CYC),
      .DLY_CYC (LO_DLY_CYC)
   ) i_lower (
      .clk      (clk),
      .rst_n    (rst_n),
      .lower_ok (pgi_lower_ok),
      .arm      (uv_arm)
   );

   // R5
   force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_held || on_req_n) |=> !pwr_good);

   // R1
   rise_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_good) |-> $past(pgi_upper_ok && !rail33_low && !rail5_low
                                && !on_req_n && !fault_held));

   // R6
   arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_arm) |-> $past(pgi_lower_ok));

   // R7
   arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pgi_lower_ok |=> !uv_arm);

endmodule

// File: tb/test_pg_delay_seq.sv
module test_pg_delay_seq;
   localparam int unsigned RS  = 30;
   localparam int unsigned RL  = 60;
   localparam int unsigned FC  = 4;
   localparam int unsigned DG  = 5;
   localparam int unsigned DL  = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up = 1'b0, lo = 1'b0, r33 = 1'b0, r5 = 1'b0, onn = 1'b1, flt = 1'b0;
   logic pg_fast, pg_slow, arm_fast, arm_slow;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pg_delay_seq #(.SLOW_VARIANT(1'b0), .RISE_LONG_CYC(RL), .RISE_SHORT_CYC(RS),
                  .FALL_CYC(FC), .LO_DEG_CYC(DG), .LO_DLY_CYC(DL)) i_pg_delay_seq (
      .clk(clk), .rst_n(rst_n), .pgi_upper_ok(up), .pgi_lower_ok(lo),
      .rail33_low(r33), .rail5_low(r5), .on_req_n(onn), .fault_held(flt),
      .pwr_good(pg_fast), .uv_arm(arm_fast));

   pg_delay_seq #(.SLOW_VARIANT(1'b1), .RISE_LONG_CYC(RL), .RISE_SHORT_CYC(RS),
                  .FALL_CYC(FC), .LO_DEG_CYC(DG), .LO_DLY_CYC(DL)) i_pg_delay_seq_slow (
      .clk(clk), .rst_n(rst_n), .pgi_upper_ok(up), .pgi_lower_ok(lo),
      .rail33_low(r33), .rail5_low(r5), .on_req_n(onn), .fault_held(flt),
      .pwr_good(pg_slow), .uv_arm(arm_slow));

   // reference state, from the requirements
   bit m_pg [2];
   int run_ok [2];
   int run_bad [2];
   bit m_arm;
   int run_lo;

   function automatic bit mon_good();
      return up && !r33 && !r5;
   endfunction

   function automatic bit rise_good();
      return mon_good() && !onn && !flt;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         m_pg[k] = 0; run_ok[k] = 0; run_bad[k] = 0;
      end
      m_arm = 0; run_lo = 0;
   endtask

   task automatic model_edge();
      for (int k = 0; k < 2; k++) begin
         int  n = (k == 0) ? RS : RL;
         bit  old = m_pg[k];
         if (onn || flt) m_pg[k] = 0;                       // R5
         else if (!old) m_pg[k] = rise_good() && run_ok[k] >= n; // R1 R2 R3
         else if (!mon_good() && run_bad[k] >= FC) m_pg[k] = 0;  // R4
         run_ok[k]  = rise_good() ? (run_ok[k] < 1000 ? run_ok[k] + 1 : 1000) : 0;
         run_bad[k] = (old && !mon_good()) ? run_bad[k] + 1 : 0;
      end
      m_arm  = lo && run_lo >= DG + DL;                        // R6 R7
      run_lo = lo ? (run_lo < 1000 ? run_lo + 1 : 1000) : 0;
   endtask

   task automatic check(input string tag, input logic act, input bit exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      #1;
      check(tag, pg_fast, m_pg[0], "pwr_good short variant");
      check(tag, pg_slow, m_pg[1], "pwr_good long variant");
      check(tag, arm_fast, m_arm, "uv_arm");
      check(tag, arm_slow, m_arm, "uv_arm long variant");
   endtask

   task automatic drive(input bit u, input bit l, input bit a, input bit b,
                        input bit o, input bit f);
      @(negedge clk);
      up = u; lo = l; r33 = a; r5 = b; onn = o; flt = f;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int first_fast, first_slow, first_arm;
      void'($urandom(32'd4711));
      model_reset();
      // R8: reset state with every input good
      drive(1, 1, 0, 0, 0, 0);
      repeat (40) @(posedge clk);
      #1;
      check("R8", pg_fast, 1'b0, "pwr_good in reset");
      check("R8", arm_fast, 1'b0, "uv_arm in reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R6: exact edge of each rise
      first_fast = 0; first_slow = 0; first_arm = 0;
      for (int i = 1; i <= 70; i++) begin
         step("R1");
         if (pg_fast && first_fast == 0) first_fast = i;
         if (pg_slow && first_slow == 0) first_slow = i;
         if (arm_fast && first_arm == 0) first_arm = i;
      end
      check("R1", first_fast == RS + 1, 1'b1, "short rise edge");
      check("R2", first_slow == RL + 1, 1'b1, "long rise edge");
      check("R6", first_arm == DG + DL + 1, 1'b1, "uv_arm rise edge");

      // R4: short dropout keeps pwr_good, long dropout drops it
      drive(1, 1, 0, 1, 0, 0);
      repeat (FC) step("R4");
      check("R4", pg_fast, 1'b1, "held through short dropout");
      drive(1, 1, 0, 0, 0, 0);
      step("R4");
      drive(0, 1, 0, 0, 0, 0);
      repeat (FC + 1) step("R4");
      check("R4", pg_fast, 1'b0, "fell after long dropout");

      // R3: one-cycle glitch near the end of the rise restarts it
      drive(1, 1, 0, 0, 0, 0);
      repeat (RS - 1) step("R3");
      drive(1, 1, 1, 0, 0, 0);
      step("R3");
      drive(1, 1, 0, 0, 0, 0);
      repeat (RS) step("R3");
      check("R3", pg_fast, 1'b0, "restarted rise still low");
      step("R3");
      check("R3", pg_fast, 1'b1, "restarted rise complete");

      // R5: fault and released on-request force low at once
      drive(1, 1, 0, 0, 0, 1);
      step("R5");
      check("R5", pg_fast, 1'b0, "fault forces low");
      drive(1, 1, 0, 0, 0, 0);
      repeat (RS + 1) step("R5");
      drive(1, 1, 0, 0, 1, 0);
      step("R5");
      check("R5", pg_fast, 1'b0, "on-request off forces low");

      // R7: lower flag drop clears arm, short run never arms
      drive(1, 0, 0, 0, 0, 0);
      step("R7");
      check("R7", arm_fast, 1'b0, "arm drop");
      drive(1, 1, 0, 0, 0, 0);
      repeat (DG + DL) step("R6");
      check("R6", arm_fast, 1'b0, "short lower run");
      drive(1, 0, 0, 0, 0, 0);
      step("R7");
      drive(1, 1, 0, 0, 0, 0);
      repeat (DG + DL) step("R7");
      check("R7", arm_fast, 1'b0, "restart after drop");

      // random phase, mostly good levels
      for (int i = 0; i < 6000; i++) begin
         drive(($urandom % 40) != 0, ($urandom % 30) != 0, ($urandom % 60) == 0,
               ($urandom % 60) == 0, ($urandom % 150) == 0, ($urandom % 200) == 0);
         step("R4");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule